// File: doc/BRIEF.md
# Printer Port Register Handshake Model

This block is a byte-wide, register-mapped printer port whose far side behaves like a printer attached directly to it. A host bus reads and writes three byte registers: an outgoing data latch, a printer status register and a port control register. Writes to the control register drive a small handshake held in the status register. A rising edge of the control strobe bit pushes the outgoing data byte onto a valid/ready byte stream, which stands in for the printer's input.

Reads of the status register step a simulated acknowledge/busy sequence and clear the pending interrupt. No timer is involved. The interrupt is a level output. It is raised when software drives strobe low while interrupts were already enabled. A byte that the stream sink has not yet accepted waits in a one-entry buffer. A second byte arriving while that buffer is still full replaces the first and sets a sticky overflow flag on a debug output. The input data latch samples an external byte on every clock.

Top module: `printer_port`

## Requirements
- R1: Only the low 3 address bits are decoded. Offset 0 is data, offset 1 is status and offset 2 is control. A read of offsets 3 to 7 returns 0xFF, and a write to them changes no register.
- R2: After reset the outgoing data latch reads 0xFF, status reads 0xD9 and control reads 0xCC. The interrupt is low, the stream output is not valid and overflow is low.
- R3: Every control write stores the written value with bits 7 and 6 forced to 1. Control bit positions are: strobe bit 0, auto-linefeed bit 1, init bit 2, select bit 3, interrupt enable bit 4, direction bit 5.
- R4: A control write with init (bit 2) equal to 0 sets status to 0xD8. Status bit positions are: timeout bit 0, error bit 3, online bit 4, paper-out bit 5, ack bit 6, busy bit 7.
- R5: A control write with init = 1, select = 1 and strobe = 1 clears status bit 7. When the previously stored strobe bit was 0, it also emits the outgoing data latch as one stream byte. With select = 0, or with the stored strobe already 1, no byte is emitted.
- R6: A control write with init = 1, select = 1 and strobe = 0 sets the interrupt pending flag only if the previously stored control value had interrupt enable set. The irq output equals the pending flag.
- R7: A status read returns the status held before the read and clears the pending flag. If status bit 7 is 0 and stored strobe is 0, the read then clears ack when ack is set, and otherwise sets both ack and bit 7. These side effects occur once per rising edge of the read strobe, however long it is held.
- R8: A data read returns the input latch when direction (control bit 5) is 1, and the last written data byte when direction is 0.
- R9: An emitted byte is held on the stream output until it is accepted. An emit while the held byte is still unaccepted and ready is low overwrites it and sets a sticky overflow flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W | Register address; only the low 3 bits are decoded |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe; side effects occur on its rising edge |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, registered one cycle after the read edge |
| portIn | input | 8 | External byte sampled into the input latch each clock |
| outData | output | 8 | Stream byte |
| outValid | output | 1 | Stream byte is valid |
| outReady | input | 1 | Stream sink accepts the byte |
| overflow | output | 1 | Sticky flag: a held byte was overwritten |
| irq | output | 1 | Level interrupt, equal to the pending flag |

## Verification
The handshake is driven through three patterns. A strobe rise with select set must emit exactly one byte. A repeated strobe-high write and a strobe rise with select clear must emit nothing. A strobe-low write must raise the interrupt only when interrupts were already enabled, and checking it with the enable off and then on separates the "previous control value" rule from a "new value" rule. Status reads are walked through the full ack-clear, ack-and-busy-set and idle states, and one read is held for several cycles to show that the sequence steps only once. The stream sink is stalled during two emits to expose the overwrite and the sticky overflow. A scoreboard matches every accepted byte against the expected order.

// File: rtl/prn_pkg.sv
package prn_pkg;
  localparam int BYTE_W = 8;
  localparam int OFF_W  = 3;

  localparam logic [OFF_W-1:0] OFF_DATA = 3'd0;
  localparam logic [OFF_W-1:0] OFF_STAT = 3'd1;
  localparam logic [OFF_W-1:0] OFF_CTRL = 3'd2;

  // control bit positions
  localparam int C_STROBE = 0;
  localparam int C_INIT   = 2;
  localparam int C_SELECT = 3;
  localparam int C_INTEN  = 4;
  localparam int C_DIR    = 5;
  // status bit positions
  localparam int S_ACK    = 6;
  localparam int S_BUSY   = 7;

  localparam logic [BYTE_W-1:0] CTRL_FORCE  = 8'hC0;
  localparam logic [BYTE_W-1:0] CTRL_RESET  = 8'hCC;
  localparam logic [BYTE_W-1:0] STAT_RESET  = 8'hD9;
  localparam logic [BYTE_W-1:0] STAT_INIT   = 8'hD8;
  localparam logic [BYTE_W-1:0] BYTE_ONES   = 8'hFF;

  typedef struct packed {
    logic loadData;
    logic loadCtrl;
    logic initStatus;
    logic clearBusy;
    logic pushByte;
    logic setPending;
    logic clearPending;
    logic ackClear;
    logic ackBusySet;
    logic loadRdata;
  } prnStrobe_t;
endpackage

// File: rtl/prn_ctrl.sv
module prn_ctrl
  import prn_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic                busWr,
  input  logic                busRd,
  input  logic [BYTE_W-1:0]   busWdata,
  input  logic [BYTE_W-1:0]   ctrlQ,
  input  logic [BYTE_W-1:0]   statusQ,
  output logic [OFF_W-1:0]    offset,
  output prnStrobe_t          stb
);
  logic rdPrev;
  logic rdPulse;
  logic ctrlWr;
  logic statRd;
  logic armed;
  logic stepOk;
  logic unusedBits;

  assign unusedBits = ^{busWdata[7:4], busWdata[1], ctrlQ[7:5], ctrlQ[3:1],
                        statusQ[5:0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdPrev <= 1'b0;
    else       rdPrev <= busRd;
  end

  assign offset  = busAddr[OFF_W-1:0];
  assign rdPulse = busRd && !rdPrev;
  assign ctrlWr  = busWr && (offset == OFF_CTRL);
  assign statRd  = rdPulse && (offset == OFF_STAT);
  assign armed   = busWdata[C_INIT] && busWdata[C_SELECT];
  assign stepOk  = statRd && !statusQ[S_BUSY] && !ctrlQ[C_STROBE];

  always_comb begin
    stb              = '0;
    stb.loadData     = busWr && (offset == OFF_DATA);
    stb.loadCtrl     = ctrlWr;
    stb.initStatus   = ctrlWr && !busWdata[C_INIT];
    stb.clearBusy    = ctrlWr && armed && busWdata[C_STROBE];
    stb.pushByte     = stb.clearBusy && !ctrlQ[C_STROBE];
    stb.setPending   = ctrlWr && armed && !busWdata[C_STROBE] && ctrlQ[C_INTEN];
    stb.clearPending = statRd;
    stb.ackClear     = stepOk && statusQ[S_ACK];
    stb.ackBusySet   = stepOk && !statusQ[S_ACK];
    stb.loadRdata    = rdPulse;
  end
endmodule

// File: rtl/prn_datapath.sv
module prn_datapath
  import prn_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  prnStrobe_t         stb,
  input  logic [OFF_W-1:0]   offset,
  input  logic [BYTE_W-1:0]  busWdata,
  input  logic [BYTE_W-1:0]  portIn,
  input  logic               outReady,
  output logic [BYTE_W-1:0]  busRdata,
  output logic [BYTE_W-1:0]  outData,
  output logic               outValid,
  output logic               overflow,
  output logic               irq,
  output logic [BYTE_W-1:0]  ctrlQ,
  output logic [BYTE_W-1:0]  statusQ
);
  logic [BYTE_W-1:0] dataW;
  logic [BYTE_W-1:0] dataIn;
  logic [BYTE_W-1:0] rdMux;
  logic              pending;

  always_comb begin
    case (offset)
      OFF_DATA: rdMux = ctrlQ[C_DIR] ? dataIn : dataW;
      OFF_STAT: rdMux = statusQ;
      OFF_CTRL: rdMux = ctrlQ;
      default:  rdMux = BYTE_ONES;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataW    <= BYTE_ONES;
      dataIn   <= BYTE_ONES;
      statusQ  <= STAT_RESET;
      ctrlQ    <= CTRL_RESET;
      pending  <= 1'b0;
      outValid <= 1'b0;
      outData  <= '0;
      overflow <= 1'b0;
      busRdata <= BYTE_ONES;
    end else begin
      dataIn <= portIn;
      if (stb.loadData) dataW <= busWdata;
      if (stb.loadCtrl) ctrlQ <= busWdata | CTRL_FORCE;

      if (stb.initStatus) statusQ <= STAT_INIT;
      else if (stb.clearBusy) statusQ[S_BUSY] <= 1'b0;
      else if (stb.ackClear) statusQ[S_ACK] <= 1'b0;
      else if (stb.ackBusySet) begin
        statusQ[S_ACK]  <= 1'b1;
        statusQ[S_BUSY] <= 1'b1;
      end

      if (stb.setPending) pending <= 1'b1;
      else if (stb.clearPending) pending <= 1'b0;

      if (stb.pushByte) begin
        outData  <= dataW;
        outValid <= 1'b1;
        if (outValid && !outReady) overflow <= 1'b1;
      end else if (outValid && outReady) begin
        outValid <= 1'b0;
      end

      if (stb.loadRdata) busRdata <= rdMux;
    end
  end

  assign irq = pending;
endmodule

// File: rtl/printer_port.sv
module printer_port
  import prn_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWr,
  input  logic               busRd,
  input  logic [7:0]         busWdata,
  output logic [7:0]         busRdata,
  input  logic [7:0]         portIn,
  output logic [7:0]         outData,
  output logic               outValid,
  input  logic               outReady,
  output logic               overflow,
  output logic               irq
);
  prnStrobe_t        stb;
  logic [OFF_W-1:0]  offset;
  logic [BYTE_W-1:0] ctrlVal;
  logic [BYTE_W-1:0] statusVal;
  logic              unusedHi;

  generate
    if (ADDR_W > OFF_W) begin : g_hi
      assign unusedHi = ^busAddr[ADDR_W-1:OFF_W];
    end else begin : g_nohi
      assign unusedHi = 1'b0;
    end
  endgenerate

  prn_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .ctrlQ(ctrlVal), .statusQ(statusVal),
    .offset(offset), .stb(stb)
  );

  prn_datapath i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .offset(offset), .busWdata(busWdata),
    .portIn(portIn), .outReady(outReady), .busRdata(busRdata),
    .outData(outData), .outValid(outValid), .overflow(overflow), .irq(irq),
    .ctrlQ(ctrlVal), .statusQ(statusVal)
  );
endmodule

// File: rtl/printer_port_chk.sv
module printer_port_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWr,
  input logic              busRd,
  input logic [7:0]        busWdata,
  input logic              outValid,
  input logic              outReady,
  input logic              overflow,
  input logic              irq,
  input logic [7:0]        ctrlVal,
  input logic [7:0]        statusVal
);
  logic ctrlWr;
  assign ctrlWr = busWr && (busAddr[2:0] == 3'd2);

  // R4
  p_init_status_r4: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWr && !busWdata[2] |=> statusVal == 8'hD8);

  // R5
  p_strobe_emit_r5: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWr && busWdata[3] && busWdata[2] && busWdata[0] && !ctrlVal[0] |=> outValid);

  // R6
  p_irq_needs_en_r6: assert property (@(posedge clk) disable iff (!rstN)
    !irq && !(ctrlWr && ctrlVal[4]) |=> !irq);

  // R7
  p_read_clears_irq_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busRd) && (busAddr[2:0] == 3'd1) && !busWr |=> !irq);

  // R9
  p_hold_byte_r9: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid);

  // R9
  p_no_overflow_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);
endmodule

bind printer_port printer_port_chk #(.ADDR_W(ADDR_W)) i_chk (.*);

// File: tb/test_printer_port.sv
module test_printer_port;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [AW-1:0] busAddr = '0;
  logic busWr = 1'b0, busRd = 1'b0;
  logic [7:0] busWdata = '0, busRdata, portIn = 8'h00, outData;
  logic outValid, outReady = 1'b1, overflow, irq;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [7:0] expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  printer_port #(.ADDR_W(AW)) i_printer_port (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .portIn(portIn),
    .outData(outData), .outValid(outValid), .outReady(outReady),
    .overflow(overflow), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, input int holdCycles, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    for (int i = 0; i < holdCycles; i++) @(negedge clk);
    d = busRdata;
    busRd = 1'b0;
  endtask

  // scoreboard monitor: a transfer happens on the edge after valid&ready is seen
  always @(negedge clk) begin
    if (rstN && outValid && outReady) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL R5 unexpected byte got %02h expected none", outData);
      end else begin
        logic [7:0] e;
        e = expQ.pop_front();
        if (outData !== e) begin
          errors++;
          $display("FAIL R5 stream byte got %02h expected %02h", outData, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R2 reset state
    check("R2 irq", {7'd0, irq}, 8'd0);
    check("R2 outValid", {7'd0, outValid}, 8'd0);
    check("R2 overflow", {7'd0, overflow}, 8'd0);
    rd(4'd0, 1, v); check("R2 data", v, 8'hFF);
    rd(4'd2, 1, v); check("R2 control", v, 8'hCC);
    rd(4'd1, 1, v); check("R2 status", v, 8'hD9);

    // R1 decode
    for (int a = 3; a < 8; a++) begin
      rd(AW'(a), 1, v); check("R1 unused offset read", v, 8'hFF);
    end
    wr(4'd5, 8'h00);
    wr(4'd7, 8'h00);
    rd(4'd2, 1, v); check("R1 ignored write ctrl", v, 8'hCC);
    rd(4'd0, 1, v); check("R1 ignored write data", v, 8'hFF);
    rd(4'hA, 1, v); check("R1 address masked", v, 8'hCC);

    // R3 forced top bits
    wr(4'd2, 8'h0C);
    rd(4'd2, 1, v); check("R3 bits 7:6 forced", v, 8'hCC);

    // R5 strobe edge emit
    wr(4'd0, 8'hA5);
    expQ.push_back(8'hA5);
    wr(4'd2, 8'hCD);
    rd(4'd1, 1, v); check("R5 busy cleared", v, 8'h59);
    rd(4'd1, 1, v); check("R7 no step while strobe high", v, 8'h59);
    wr(4'd2, 8'hCD);   // stored strobe already 1: no byte
    wr(4'd2, 8'hCC);
    check("R6 no irq without prior enable", {7'd0, irq}, 8'd0);

    // R7 ack/busy sequence
    rd(4'd1, 1, v); check("R7 step1 returns", v, 8'h59);
    rd(4'd1, 1, v); check("R7 ack cleared", v, 8'h19);
    rd(4'd1, 1, v); check("R7 ack busy set", v, 8'hD9);

    // R5 select low: no byte
    wr(4'd2, 8'hC5);
    check("R5 select low no emit", {7'd0, outValid}, 8'd0);
    wr(4'd2, 8'hCC);

    // R7 held read steps once
    expQ.push_back(8'hA5);
    wr(4'd2, 8'hCD);
    wr(4'd2, 8'hCC);
    rd(4'd1, 4, v); check("R7 held read value", v, 8'h59);
    rd(4'd1, 1, v); check("R7 held read stepped once", v, 8'h19);

    // R4 init low
    wr(4'd2, 8'h08);
    rd(4'd1, 1, v); check("R4 status init", v, 8'hD8);
    rd(4'd2, 1, v); check("R4 ctrl readback", v, 8'hC8);
    wr(4'd2, 8'hCC);

    // R6 interrupt uses previous enable
    wr(4'd2, 8'hDC);
    check("R6 new enable alone", {7'd0, irq}, 8'd0);
    wr(4'd2, 8'hDC);
    check("R6 irq raised", {7'd0, irq}, 8'd1);
    rd(4'd1, 1, v); check("R7 status while pending", v, 8'hD8);
    check("R7 read clears irq", {7'd0, irq}, 8'd0);

    // R8 direction mux
    portIn = 8'h5A;
    wr(4'd2, 8'hEC);
    rd(4'd0, 1, v); check("R8 input latch", v, 8'h5A);
    wr(4'd2, 8'hCC);
    rd(4'd0, 1, v); check("R8 written data", v, 8'hA5);
    rd(4'd1, 1, v);
    check("R6 irq cleared again", {7'd0, irq}, 8'd0);

    // R9 overflow with stalled sink
    repeat (2) @(negedge clk);
    outReady = 1'b0;
    wr(4'd0, 8'h11);
    wr(4'd2, 8'hCD);
    check("R9 held byte", outData, 8'h11);
    check("R9 no overflow yet", {7'd0, overflow}, 8'd0);
    wr(4'd2, 8'hCC);
    wr(4'd0, 8'h22);
    expQ.push_back(8'h22);
    wr(4'd2, 8'hCD);
    check("R9 overwritten byte", outData, 8'h22);
    check("R9 overflow set", {7'd0, overflow}, 8'd1);
    outReady = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 overflow sticky", {7'd0, overflow}, 8'd1);
    check("R9 drained", {7'd0, outValid}, 8'd0);
    check("R5 all bytes seen", 8'(expQ.size()), 8'd0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule